// File: doc/BRIEF.md
# Store buffer with fence ordering

This block sits between a simple in-order core and a data cache. The core hands it one request per cycle: a store, a load, or one of three fences (store-only, load-only, full). Stores wait in a small FIFO and go to the cache store port one at a time, always from the oldest entry. A load whose address hits a buffered store takes the youngest matching data straight from the buffer. Any other load goes out on the cache load port. The cache returns its responses in order, and the block passes them back to the core.

A store fence never stalls the core. It records how many stores were already queued when it arrived and counts them down as they commit. Younger stores keep being queued behind them, and the head-only commit order keeps them behind the older stores. A load fence holds only younger loads, and only until every earlier cache load has returned. A full fence counts down its older stores in the same way. It also keeps every younger load away from both the cache and the forwarding path until those stores have committed and no load is outstanding. A store fence followed by a load fence is deliberately weaker than a full fence. Fence completion is reported as the number of fences finishing in each cycle.

Top module: `store_order_buffer`

## Requirements
- R1: While reset is held and in the first cycle after it, the cache store valid, the cache load valid, the core load response valid and the fence-completion count are all 0.
- R2: A store (request code 0) is accepted when the buffer holds fewer than DEPTH entries. When it holds DEPTH entries, ready is low for a store.
- R3: The cache store valid is high exactly when the buffer is non-empty. Its address and data are those of the oldest entry, and that entry leaves only on a valid/ready handshake. At most one store leaves per cycle, in acceptance order.
- R4: When no cache load is outstanding, a load (code 1) that hits one or more buffered stores is accepted and answered in the same cycle with the data of the youngest matching store, and no cache load is requested. If cache loads are outstanding, such a load is not accepted.
- R5: A load (code 1) that hits no buffered store raises the cache load valid and is accepted when the cache load ready is high. At most MAXLD cache loads may be outstanding. Each cache response is passed to the core response in the same cycle.
- R6: A store fence (code 2) is accepted without waiting for the buffer and does not hold stores or loads. It adds 1 to the completion count in the cycle after the last store that was buffered when it arrived has committed, or in the cycle after acceptance if the buffer was empty.
- R7: A load fence (code 3) is always accepted. While any cache load accepted before it is outstanding, loads are not accepted. Stores are still accepted.
- R8: A full fence (code 4) holds every younger load, forwarded or not, until all stores buffered when it arrived have committed and no cache load is outstanding. It then adds 1 to the completion count, one cycle after that condition is first true. Younger stores are still accepted during the hold.
- R9: After a store fence and then a load fence, with no cache load outstanding, a load that hits no buffered store is sent to the cache even while older stores are still buffered.
- R10: A store fence or full fence is refused (ready low) while all NFENCE fence trackers are busy. A tracker is busy from the cycle after acceptance through its completion cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Core request valid |
| reqReady | output | 1 | Request accepted this cycle when high together with valid |
| reqKind | input | 3 | 0 store, 1 load, 2 store fence, 3 load fence, 4 full fence |
| reqAddr | input | AW | Store or load address |
| reqData | input | DW | Store data |
| cStValid | output | 1 | Cache store request valid |
| cStReady | input | 1 | Cache takes the store |
| cStAddr | output | AW | Address of the oldest buffered store |
| cStData | output | DW | Data of the oldest buffered store |
| cLdValid | output | 1 | Cache load request valid |
| cLdReady | input | 1 | Cache takes the load |
| cLdAddr | output | AW | Cache load address |
| cRspValid | input | 1 | In-order cache load response valid |
| cRspData | input | DW | Cache load response data |
| ldRspValid | output | 1 | Load data returned to the core |
| ldRspData | output | DW | Returned load data |
| fenceDoneNum | output | clog2(NFENCE+1) | Number of store and full fences completing this cycle |

## Verification
The bench builds the block with DEPTH of 4, NFENCE of 2 and MAXLD of 2. With these values a few quick stores fill the buffer, two fences use up every tracker, and two cache loads reach the outstanding limit, so the refusal paths of R2, R5 and R10 are exercised often during the random traffic. A small address range makes hits against several buffered stores common, which exercises youngest-match forwarding. A stalled store port then holds stores in the buffer, and in that state the bench shows that a store fence plus a load fence lets a load pass to the cache while a full fence holds it back.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [2:0] {
    OP_STORE  = 3'd0,
    OP_LOAD   = 3'd1,
    OP_SFENCE = 3'd2,
    OP_LFENCE = 3'd3,
    OP_FULL   = 3'd4
  } sbOp_e;

  typedef struct packed {
    logic push;
    logic pop;
  } sbStrobe_t;
endpackage

// File: rtl/sb_datapath.sv
module sb_datapath import sb_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int AW = 16,
  parameter int DW = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  sbStrobe_t     strobe,
  input  logic [AW-1:0] pushAddr,
  input  logic [DW-1:0] pushData,
  input  logic [AW-1:0] lookAddr,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          hit,
  output logic [DW-1:0] fwdData,
  output logic [AW-1:0] headAddr,
  output logic [DW-1:0] headData
);
  // DEPTH is expected to be a power of two so that the pointers wrap naturally.
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0] addrMem [DEPTH];
  logic [DW-1:0] dataMem [DEPTH];
  logic [PW-1:0] headPtr, tailPtr;

  always_ff @(posedge clk) begin
    if (strobe.push) begin
      addrMem[tailPtr] <= pushAddr;
      dataMem[tailPtr] <= pushData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
      count   <= '0;
    end else begin
      if (strobe.pop)  headPtr <= headPtr + 1'b1;
      if (strobe.push) tailPtr <= tailPtr + 1'b1;
      count <= count + CW'(strobe.push) - CW'(strobe.pop);
    end
  end

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign headAddr = addrMem[headPtr];
  assign headData = dataMem[headPtr];

  // Walk from oldest to youngest; the last match seen is the youngest store.
  always_comb begin
    logic [PW-1:0] idx;
    hit     = 1'b0;
    fwdData = '0;
    for (int i = 0; i < DEPTH; i++) begin
      idx = headPtr + PW'(i);
      if (i < int'(count) && addrMem[idx] == lookAddr) begin
        hit     = 1'b1;
        fwdData = dataMem[idx];
      end
    end
  end

  // R2: the control never pushes into a full buffer
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> (count < CW'(DEPTH)));
endmodule

// File: rtl/sb_control.sv
module sb_control import sb_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int NFENCE = 2,
  parameter int MAXLD = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int NW = $clog2(NFENCE + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  sbOp_e         reqOp,
  input  logic [CW-1:0] count,
  input  logic          empty,
  input  logic          full,
  input  logic          hit,
  input  logic          cStReady,
  input  logic          cLdReady,
  input  logic          cRspValid,
  output sbStrobe_t     strobe,
  output logic          reqReady,
  output logic          cStValid,
  output logic          cLdValid,
  output logic          fwdAcc,
  output logic [NW-1:0] fenceDoneNum
);
  localparam int OW = $clog2(MAXLD + 1);

  logic [OW-1:0]     outst;
  logic              ldHold;
  logic [NFENCE-1:0] slotAct, slotFull, slotDone, allocOH;
  logic [CW-1:0]     slotRem [NFENCE];
  logic [CW-1:0]     remNew;
  logic fullHold, ldBlock, isLoad, accept, fenceAcc, ldIssue, anyFree;

  generate
    for (genvar j = 0; j < NFENCE; j++) begin : g_slot
      assign slotDone[j] = slotAct[j] && (slotRem[j] == '0) &&
                           (!slotFull[j] || outst == '0);
    end
  endgenerate

  always_comb begin
    logic found;
    found   = 1'b0;
    allocOH = '0;
    for (int j = 0; j < NFENCE; j++) begin
      if (!slotAct[j] && !found) begin
        allocOH[j] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  assign anyFree  = ~&slotAct;
  assign fullHold = |(slotAct & slotFull);
  assign ldBlock  = fullHold || (ldHold && outst != '0) || (outst == OW'(MAXLD));
  assign isLoad   = reqValid && (reqOp == OP_LOAD) && !ldBlock;
  assign cLdValid = isLoad && !hit;
  assign fwdAcc   = isLoad && hit && (outst == '0);
  assign cStValid = !empty;
  assign ldIssue  = cLdValid && cLdReady;

  always_comb begin
    case (reqOp)
      OP_STORE:           reqReady = !full;
      OP_LOAD:            reqReady = !ldBlock && (hit ? (outst == '0) : cLdReady);
      OP_SFENCE, OP_FULL: reqReady = anyFree;
      OP_LFENCE:          reqReady = 1'b1;
      default:            reqReady = 1'b0;
    endcase
  end

  assign accept      = reqValid && reqReady;
  assign fenceAcc    = accept && (reqOp == OP_SFENCE || reqOp == OP_FULL);
  assign strobe.push = accept && (reqOp == OP_STORE);
  assign strobe.pop  = cStValid && cStReady;
  assign remNew      = count - CW'(strobe.pop);

  always_comb begin
    fenceDoneNum = '0;
    for (int j = 0; j < NFENCE; j++) fenceDoneNum = fenceDoneNum + NW'(slotDone[j]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outst    <= '0;
      ldHold   <= 1'b0;
      slotAct  <= '0;
      slotFull <= '0;
      for (int j = 0; j < NFENCE; j++) slotRem[j] <= '0;
    end else begin
      outst <= outst + OW'(ldIssue) - OW'(cRspValid);
      if (accept && reqOp == OP_LFENCE) ldHold <= (outst != '0);
      else if (outst == '0)             ldHold <= 1'b0;
      for (int j = 0; j < NFENCE; j++) begin
        if (slotDone[j]) begin
          slotAct[j] <= 1'b0;
        end else if (fenceAcc && allocOH[j]) begin
          slotAct[j]  <= 1'b1;
          slotFull[j] <= (reqOp == OP_FULL);
          slotRem[j]  <= remNew;
        end else if (slotAct[j] && strobe.pop && slotRem[j] != '0) begin
          slotRem[j] <= slotRem[j] - 1'b1;
        end
      end
    end
  end

  // R5: never more cache loads in flight than allowed
  a_r5_outst_bound: assert property (@(posedge clk) disable iff (!rstN)
    outst <= OW'(MAXLD));
  // R5: the cache only answers loads that were issued
  a_r5_rsp_has_load: assert property (@(posedge clk) disable iff (!rstN)
    cRspValid |-> (outst != '0));
  // R7: a pending load fence keeps younger loads off both paths
  a_r7_lfence_block: assert property (@(posedge clk) disable iff (!rstN)
    (ldHold && outst != '0) |-> (!cLdValid && !fwdAcc));
  // R8: a live full fence lets no load reach the cache
  a_r8_full_blocks: assert property (@(posedge clk) disable iff (!rstN)
    fullHold |-> !cLdValid);
endmodule

// File: rtl/store_order_buffer.sv
module store_order_buffer import sb_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int NFENCE = 2,
  parameter int MAXLD = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int NW = $clog2(NFENCE + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic [2:0]    reqKind,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqData,
  output logic          cStValid,
  input  logic          cStReady,
  output logic [AW-1:0] cStAddr,
  output logic [DW-1:0] cStData,
  output logic          cLdValid,
  input  logic          cLdReady,
  output logic [AW-1:0] cLdAddr,
  input  logic          cRspValid,
  input  logic [DW-1:0] cRspData,
  output logic          ldRspValid,
  output logic [DW-1:0] ldRspData,
  output logic [NW-1:0] fenceDoneNum
);
  sbStrobe_t     strobe;
  logic [CW-1:0] count;
  logic          full, empty, hit, fwdAcc;
  logic [DW-1:0] fwdData;

  sb_datapath #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .pushAddr(reqAddr), .pushData(reqData), .lookAddr(reqAddr),
    .count(count), .full(full), .empty(empty), .hit(hit), .fwdData(fwdData),
    .headAddr(cStAddr), .headData(cStData)
  );

  sb_control #(.DEPTH(DEPTH), .NFENCE(NFENCE), .MAXLD(MAXLD)) u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(sbOp_e'(reqKind)),
    .count(count), .empty(empty), .full(full), .hit(hit),
    .cStReady(cStReady), .cLdReady(cLdReady), .cRspValid(cRspValid),
    .strobe(strobe), .reqReady(reqReady), .cStValid(cStValid),
    .cLdValid(cLdValid), .fwdAcc(fwdAcc), .fenceDoneNum(fenceDoneNum)
  );

  assign cLdAddr    = reqAddr;
  assign ldRspValid = fwdAcc || cRspValid;
  assign ldRspData  = fwdAcc ? fwdData : cRspData;

  // R3: a stalled head store holds its address and data
  a_r3_head_stable: assert property (@(posedge clk) disable iff (!rstN)
    (cStValid && !cStReady) |=> (cStValid && $stable(cStAddr) && $stable(cStData)));
  // R4: a forwarded answer never collides with a cache answer
  a_r4_one_response: assert property (@(posedge clk) disable iff (!rstN)
    fwdAcc |-> !cRspValid);
endmodule

// File: tb/tb_store_order_buffer.sv
module tb_store_order_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4, AW = 8, DW = 16, NF = 2, ML = 2;
  localparam int NW = $clog2(NF + 1);

  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqReady;
  logic [2:0] reqKind = 0;
  logic [AW-1:0] reqAddr = 0, cStAddr, cLdAddr;
  logic [DW-1:0] reqData = 0, cStData, cRspData = 0, ldRspData;
  logic cStValid, cStReady = 0, cLdValid, cLdReady = 0, cRspValid = 0, ldRspValid;
  logic [NW-1:0] fenceDoneNum;

  store_order_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .NFENCE(NF), .MAXLD(ML)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqData(reqData), .cStValid(cStValid), .cStReady(cStReady),
    .cStAddr(cStAddr), .cStData(cStData), .cLdValid(cLdValid), .cLdReady(cLdReady),
    .cLdAddr(cLdAddr), .cRspValid(cRspValid), .cRspData(cRspData),
    .ldRspValid(ldRspValid), .ldRspData(ldRspData), .fenceDoneNum(fenceDoneNum));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int compared = 0, mismatched = 0, cyc = 0;
  int forceSt = -1, forceLd = -1;
  int qa[$], qd[$], rqA[$], rqDue[$];
  int sAct[NF], sFull[NF], sRem[NF];
  int outst = 0, lHold = 0, lastDue = 0;

  function automatic int rspOf(int a);
    return (a * 7 + 3) & 16'hFFFF;
  endfunction

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  task automatic cycle(input int v, input int k, input int a, input int d);
    int hitM, hitD, mHold, blk, anyFree, eReady, isLd, eLdV, fwd, eRspV, eRspD, eDone, eStV;
    int acc, pop, newOut, free[NF], slotJ;
    @(negedge clk);
    cyc++;
    reqValid = v[0]; reqKind = k[2:0]; reqAddr = a[AW-1:0]; reqData = d[DW-1:0];
    cStReady = (forceSt < 0) ? 1'($urandom % 2) : forceSt[0];
    cLdReady = (forceLd < 0) ? ($urandom % 10 < 7) : forceLd[0];
    cRspValid = (rqA.size() > 0) && (rqDue[0] <= cyc);
    cRspData = cRspValid ? DW'(rspOf(rqA[0])) : '0;
    #1;
    hitM = 0; hitD = 0;
    foreach (qa[i]) if (qa[i] == a) begin hitM = 1; hitD = qd[i]; end
    mHold = 0; anyFree = 0; eDone = 0;
    for (int j = 0; j < NF; j++) begin
      if (sAct[j] != 0 && sFull[j] != 0) mHold = 1;
      free[j] = (sAct[j] == 0);
      if (free[j] != 0) anyFree = 1;
      if (sAct[j] != 0 && sRem[j] == 0 && (sFull[j] == 0 || outst == 0)) eDone++;
    end
    blk = (mHold != 0) || (lHold != 0 && outst != 0) || (outst == ML);
    case (k)
      0: eReady = (qa.size() < DEPTH);
      1: eReady = !blk && (hitM != 0 ? outst == 0 : cLdReady == 1'b1);
      2, 4: eReady = anyFree;
      3: eReady = 1;
      default: eReady = 0;
    endcase
    isLd = v != 0 && k == 1 && !blk;
    eLdV = isLd && hitM == 0;
    fwd = isLd && hitM != 0 && outst == 0;
    eRspV = fwd || cRspValid;
    eRspD = fwd ? hitD : int'(cRspData);
    eStV = qa.size() > 0;
    case (k)
      0: chk("R2 reqReady", int'(reqReady), eReady);
      1: chk("R5 reqReady", int'(reqReady), eReady);
      3: chk("R7 reqReady", int'(reqReady), eReady);
      default: chk("R10 reqReady", int'(reqReady), eReady);
    endcase
    chk("R3 cStValid", int'(cStValid), eStV);
    if (eStV != 0) begin
      chk("R3 cStAddr", int'(cStAddr), qa[0]);
      chk("R3 cStData", int'(cStData), qd[0]);
    end
    chk("R5 cLdValid", int'(cLdValid), eLdV);
    chk("R4 ldRspValid", int'(ldRspValid), eRspV);
    if (eRspV != 0) chk("R4 ldRspData", int'(ldRspData), eRspD);
    chk("R6/R8 fenceDoneNum", int'(fenceDoneNum), eDone);
    acc = v != 0 && eReady != 0;
    pop = eStV != 0 && cStReady;
    for (int j = 0; j < NF; j++) begin
      if (sAct[j] != 0 && sRem[j] == 0 && (sFull[j] == 0 || outst == 0)) sAct[j] = 0;
      else if (sAct[j] != 0 && pop != 0 && sRem[j] > 0) sRem[j]--;
    end
    if (acc != 0 && (k == 2 || k == 4)) begin
      slotJ = -1;
      for (int j = 0; j < NF; j++) if (free[j] != 0 && slotJ < 0) slotJ = j;
      sAct[slotJ] = 1; sFull[slotJ] = (k == 4); sRem[slotJ] = qa.size() - pop;
    end
    if (pop != 0) begin void'(qa.pop_front()); void'(qd.pop_front()); end
    if (acc != 0 && k == 0) begin qa.push_back(a); qd.push_back(d & 16'hFFFF); end
    newOut = outst + ((eLdV != 0 && cLdReady) ? 1 : 0) - (cRspValid ? 1 : 0);
    if (acc != 0 && k == 3) lHold = (outst != 0);
    else if (outst == 0) lHold = 0;
    outst = newOut;
    if (cRspValid) begin void'(rqA.pop_front()); void'(rqDue.pop_front()); end
    if (eLdV != 0 && cLdReady) begin
      lastDue = (cyc + 1 + int'($urandom % 3) > lastDue) ? cyc + 1 + int'($urandom % 3) : lastDue;
      if (lastDue <= cyc) lastDue = cyc + 1;
      rqA.push_back(a); rqDue.push_back(lastDue);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    mismatched++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    summary();
    $finish;
  end

  initial begin
    int kind, r;
    for (int j = 0; j < NF; j++) begin sAct[j] = 0; sFull[j] = 0; sRem[j] = 0; end
    repeat (3) begin
      @(negedge clk); #1;
      chk("R1 cStValid in reset", int'(cStValid), 0);
      chk("R1 cLdValid in reset", int'(cLdValid), 0);
      chk("R1 ldRspValid in reset", int'(ldRspValid), 0);
      chk("R1 fenceDoneNum in reset", int'(fenceDoneNum), 0);
    end
    rstN = 1;
    cycle(0, 0, 0, 0);
    chk("R1 cStValid after reset", int'(cStValid), 0);
    // Random traffic over a small address range
    for (int n = 0; n < 4000; n++) begin
      r = int'($urandom % 100);
      kind = (r < 40) ? 0 : (r < 75) ? 1 : (r < 83) ? 2 : (r < 91) ? 3 : 4;
      cycle(int'($urandom % 8 != 0), kind, int'($urandom % 6), int'($urandom));
    end
    forceSt = 1; forceLd = 1;
    for (int n = 0; n < 40; n++) cycle(0, 0, 0, 0);
    // Directed: stalled store port
    forceSt = 0;
    cycle(1, 0, 1, 16'h00A1);
    cycle(1, 2, 0, 0);
    cycle(1, 3, 0, 0);
    cycle(1, 1, 7, 0);
    chk("R9 load reaches cache behind store+load fence", int'(cLdValid), 1);
    chk("R9 older store still buffered", int'(cStValid), 1);
    for (int n = 0; n < 6; n++) cycle(0, 0, 0, 0);
    cycle(1, 0, 3, 16'h0011);
    cycle(1, 0, 3, 16'h0022);
    cycle(1, 1, 3, 0);
    chk("R4 forwarded valid", int'(ldRspValid), 1);
    chk("R4 youngest match data", int'(ldRspData), 16'h0022);
    chk("R4 no cache load on hit", int'(cLdValid), 0);
    cycle(1, 4, 0, 0);
    cycle(1, 1, 7, 0);
    chk("R8 load held by full fence", int'(cLdValid), 0);
    chk("R8 load not accepted", int'(reqReady), 0);
    cycle(1, 1, 3, 0);
    chk("R8 forwarding also held", int'(ldRspValid), 0);
    cycle(1, 0, 5, 16'h0055);
    cycle(1, 0, 6, 16'h0066);
    chk("R2 store refused when full", int'(reqReady), 0);
    cycle(1, 2, 0, 0);
    chk("R10 fence refused with trackers busy", int'(reqReady), 0);
    forceSt = 1;
    for (int n = 0; n < 20; n++) cycle(0, 0, 0, 0);
    cycle(1, 1, 7, 0);
    chk("R8 load released after drain", int'(cLdValid), 1);
    for (int n = 0; n < 10; n++) cycle(0, 0, 0, 0);
    summary();
    $finish;
  end
endmodule